// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port behind a zero-wait APB slave. Each line can be turned into an output or left as an input through a byte-wide direction register. The output levels live in a byte-wide output register that drives the pad output bus. The pad output-enable bus follows the direction register bit for bit. Pad inputs pass through a two-flop synchronizer before software can read them.

The data register has no mask register of its own. Its bit mask is taken from the access address. Any address whose two top bits are zero selects the data window. Address bits 9 down to 2 then form an eight-bit mask, and address bit n+2 selects line n. A write changes only the selected lines, so one line can be set or cleared in a single write without reading first. A read returns zero on every line that is not selected.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset the direction register, the output register and both synchronizer stages are 0. So pad_oe = 0x00, pad_out = 0x00 and a read at 0x400 returns 0x00.
- R2: Every address with paddr[11:10] = 2'b00 selects the data window, whatever paddr[1:0] holds. The mask is paddr[9:2], and mask bit n (address bit n+2) selects line n.
- R3: A read of the data window returns 0 on every line whose mask bit is 0.
- R4: A write to the data window (psel, penable and pwrite all 1) loads pwdata bit n into output register bit n only where mask bit n is 1. All other output bits keep their value.
- R5: The direction register sits at exactly 0x400 and is read and written as a whole byte. Bit n = 1 makes line n an output. pad_oe[n] equals direction bit n.
- R6: On a data-window read, a line whose mask bit is 1 returns its output register bit when it is an output. It returns its synchronized pad input bit when it is an input.
- R7: A change on pad_in first shows in a data-window read after the second rising pclk edge that follows it. After only one edge, the read still shows the old level.
- R8: pad_out[n] always equals output register bit n, including while line n is an input.
- R9: Every transfer completes with no wait state: pready is always 1 and pslverr is always 0.
- R10: A read at any address outside the data window and other than 0x400 returns 0x00. A write there changes neither register.
- R11: Writing pwdata with bit n set to address 1 << (n+2) sets line n alone. Writing 0x00 to the same address clears line n alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the port |
| pwdata | input | 8 | Write data, bit n for line n |
| prdata | output | 8 | Read data, valid during a read access phase |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables, 1 drives the pad |

## Verification
The assertions assume a well-formed APB sequence. That means a setup cycle with psel high and penable low, followed by one access cycle with penable high, with paddr, pwrite and pwdata held stable across both cycles. The checks on read data and register updates are only meaningful under that assumption. Every bench transfer goes through one task that produces exactly this two-cycle sequence and then idles the bus. Random traffic therefore varies only addresses, data and pad levels, never the handshake. pad_in is the one input allowed to change at any clock, and the bench toggles it on falling edges during reads and writes alike.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Which register an APB address selects
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LINES  = 8
) (
    input  logic [ADDR_W-1:0] paddr,
    output acc_kind_e         kind,
    output logic [LINES-1:0]  mask
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = LINES + MASK_LO - 1;
    localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << (MASK_HI + 1);

    always_comb begin
        mask = paddr[MASK_HI:MASK_LO];
        if (paddr[ADDR_W-1:MASK_HI+1] == '0) begin
            kind = ACC_DATA;
        end else if (paddr == DIR_OFF) begin
            kind = ACC_DIR;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int LINES  = 8,
    parameter int STAGES = 2
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic [LINES-1:0] pad_in,
    output logic [LINES-1:0] sync_out
);
    logic [STAGES-1:0][LINES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = pad_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic             wr_en,
    input  acc_kind_e        kind,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] dout_q
);
    typedef struct packed {
        logic [LINES-1:0] dir;
        logic [LINES-1:0] dout;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (kind)
                ACC_DATA: st_d.dout = (st_q.dout & ~mask) | (wdata & mask);
                ACC_DIR:  st_d.dir  = wdata;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q  = st_q.dir;
    assign dout_q = st_q.dout;

    // Masked-out lines hold, masked-in lines take the written bit
    assert_masked_write_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && kind == ACC_DATA) |=>
            ((((dout_q ^ $past(dout_q)) & ~$past(mask)) == '0) &&
             (((dout_q ^ $past(wdata)) & $past(mask)) == '0)));

    assert_dir_write_R5: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && kind == ACC_DIR) |=> (dir_q == $past(wdata)));

    assert_stray_write_R10: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && kind == ACC_NONE) |=>
            (dir_q == $past(dir_q) && dout_q == $past(dout_q)));
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [LINES-1:0]  pwdata,
    output logic [LINES-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe
);
    acc_kind_e        kind;
    logic [LINES-1:0] mask;
    logic [LINES-1:0] dir_q, dout_q, sync_in;
    logic [LINES-1:0] rd_val;
    logic             wr_en;

    assign wr_en = psel && penable && pwrite;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dec (
        .paddr (paddr),
        .kind  (kind),
        .mask  (mask)
    );

    gpio_in_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .pclk     (pclk),
        .presetn  (presetn),
        .pad_in   (pad_in),
        .sync_out (sync_in)
    );

    gpio_regs #(.LINES(LINES)) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .wr_en   (wr_en),
        .kind    (kind),
        .mask    (mask),
        .wdata   (pwdata),
        .dir_q   (dir_q),
        .dout_q  (dout_q)
    );

    // Per-line read source: output register for outputs, synchronized pad for inputs
    always_comb begin
        unique case (kind)
            ACC_DATA: rd_val = mask & ((dir_q & dout_q) | (~dir_q & sync_in));
            ACC_DIR:  rd_val = dir_q;
            default:  rd_val = '0;
        endcase
    end

    assign prdata  = (psel && !pwrite) ? rd_val : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

    assert_read_masked_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && kind == ACC_DATA) |-> ((prdata & ~mask) == '0));

    assert_read_output_lines_R6: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && kind == ACC_DATA) |->
            ((prdata & mask & pad_oe) == (pad_out & mask & pad_oe)));

    assert_stray_read_R10: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && kind == ACC_NONE) |-> (prdata == '0));

    assert_dir_readback_R5: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && kind == ACC_DIR) |-> (prdata == pad_oe));
endmodule

// File: tb/masked_gpio_port_tb.sv
module masked_gpio_port_tb;
    logic       pclk = 1'b0;
    logic       presetn = 1'b0;
    logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0] pwdata = '0;
    logic [7:0] prdata;
    logic       pready, pslverr;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;

    int total = 0;
    int bad   = 0;

    always #10 pclk = ~pclk;  // 50 MHz

    masked_gpio_port u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference model
    logic [7:0] m_dir, m_dout;
    logic [7:0] hist[$];

    always @(posedge pclk) begin
        if (!presetn) begin
            m_dir  = 8'h00;
            m_dout = 8'h00;
            hist   = {8'h00, 8'h00};
        end else begin
            hist.push_back(pad_in);
            while (hist.size() > 2) void'(hist.pop_front());
            if (psel && penable && pwrite) begin
                if (paddr[11:10] == 2'b00)
                    m_dout = (m_dout & ~paddr[9:2]) | (pwdata & paddr[9:2]);
                else if (paddr == 12'h400)
                    m_dir = pwdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [11:0] a);
        logic [7:0] m;
        if (a[11:10] == 2'b00) begin
            m = a[9:2];
            return m & ((m_dir & m_dout) | (~m_dir & hist[0]));
        end else if (a == 12'h400) begin
            return m_dir;
        end
        return 8'h00;
    endfunction

    // Compare against the model on every clock, away from the edges
    always @(negedge pclk) begin
        #2;
        if (presetn) begin
            chk("R8 R4 R11 pad_out", pad_out, m_dout);
            chk("R5 pad_oe", pad_oe, m_dir);
            chk("R9 pready", {7'd0, pready}, 8'h01);
            chk("R9 pslverr", {7'd0, pslverr}, 8'h00);
            if (psel && penable && !pwrite) begin
                if (paddr[11:10] == 2'b00)
                    chk("R2 R3 R6 R7 data read", prdata, model_read(paddr));
                else if (paddr == 12'h400)
                    chk("R5 dir read", prdata, model_read(paddr));
                else
                    chk("R10 stray read", prdata, model_read(paddr));
            end
        end
    end

    task automatic apb(input bit wr, input logic [11:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        #3 rd = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        apb(1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] v;
        apb(1'b0, a, 8'h00, v);
        chk(tag, v, exp);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk); #3;
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        rd_chk("R1 dir", 12'h400, 8'h00);

        wr(12'h400, 8'hF0);
        rd_chk("R5 dir readback", 12'h400, 8'hF0);
        wr(12'h3FC, 8'hA5);
        chk("R4 full write", pad_out, 8'hA5);
        wr(12'h03C, 8'h5A);
        chk("R4 low-nibble write", pad_out, 8'hAA);
        wr(12'h100, 8'h40);
        chk("R11 set line 6", pad_out, 8'hEA);
        wr(12'h200, 8'h00);
        chk("R11 clear line 7", pad_out, 8'h6A);

        @(negedge pclk) pad_in = 8'h3C;
        repeat (3) @(negedge pclk);
        rd_chk("R6 mixed read", 12'h3FC, 8'h6C);
        rd_chk("R3 masked read", 12'h090, 8'h24);

        @(negedge pclk) pad_in = 8'h3F;
        rd_chk("R7 after two edges", 12'h3FC, 8'h6F);

        // Setup on the same edge as the pad change: only one rising edge before access
        @(negedge pclk);
        pad_in = 8'h30; psel = 1'b1; pwrite = 1'b0; paddr = 12'h3FC;
        @(negedge pclk);
        penable = 1'b1;
        #3 chk("R7 one edge not yet", prdata, 8'h6F);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;

        rd_chk("R10 read 0x800", 12'h800, 8'h00);
        rd_chk("R10 read 0xC00", 12'hC00, 8'h00);
        rd_chk("R10 read 0x404", 12'h404, 8'h00);
        wr(12'h800, 8'hFF);
        wr(12'h401, 8'h0F);
        rd_chk("R10 dir kept", 12'h400, 8'hF0);
        chk("R10 out kept", pad_out, 8'h6A);

        wr(12'h400, 8'h00);
        chk("R8 out while input", pad_out, 8'h6A);
        chk("R5 oe cleared", pad_oe, 8'h00);
        @(negedge pclk) pad_in = 8'h81;
        repeat (3) @(negedge pclk);
        rd_chk("R2 alias low bits", 12'h3FF, 8'h81);
        rd_chk("R2 mask lines 7 and 0", 12'h204, 8'h81);
        rd_chk("R2 mask line 1", 12'h008, 8'h00);

        for (int i = 0; i < 600; i++) begin
            logic [7:0]  v;
            logic [11:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 6) a = {2'b00, 10'($urandom)};
            else if (sel < 8) a = 12'h400;
            else a = 12'($urandom);
            pad_in = 8'($urandom);
            apb(1'($urandom), a, 8'($urandom), v);
        end

        repeat (2) @(negedge pclk);
        summary();
        $finish;
    end
endmodule